// File: doc/BRIEF.md
# PHY Indirect Register Handshake Master

This block turns single register requests into the acknowledge-paced handshake that a PHY uses for its indirect 16-bit register port. That port has two words. The master drives a 20-bit control word, and the PHY returns a 17-bit status word. A request is accepted on a valid/ready interface. It carries a 16-bit register address, 16-bit write data and a direction flag.

Every transfer first latches the address in the PHY. A write then latches the data and fires the write strobe. A read fires the read strobe and captures the returned data. Each strobe is held until acknowledge is seen high, and the next step waits for acknowledge to drop again. Acknowledge is polled at a fixed interval, up to a fixed number of times. If any wait never sees the level it expects, the transfer is abandoned and the response carries a timeout flag.

Top module: `phy_regport_master`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `phy_ctrl` is all zeros.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle after the one-cycle `rsp_valid` pulse. Requests presented while `req_ready` is 0 are not taken.
- R3: Address step. `phy_ctrl[15:0]` carries the address alone for one cycle. Then bit 16 is added until acknowledge (`phy_stat[16]`) is sampled 1. Then the address alone is driven until acknowledge is sampled 0.
- R4: Write step, after R3. The data alone is driven for one cycle. Next comes data with bit 17 until ack is 1, then data alone until ack is 0. Next comes bit 18 alone (bits 15:0 zero) until ack is 1, then data alone until ack is 0. The response then follows, with `phy_ctrl` zero.
- R5: Read step, after R3. Bit 19 alone is driven until ack is 1, and `phy_stat[15:0]` is captured at that sample. Next `phy_ctrl` is zero until ack is 0. The response then returns the captured value on `rsp_rdata`.
- R6: Within a waiting step, acknowledge is examined only in the last cycle of each slot of `POLL_GAP` cycles, counted from the first cycle the step's control value is driven. Each wait takes at most `MAX_POLLS` samples, and the ack level in any other cycle has no effect.
- R7: If none of the `MAX_POLLS` samples of a wait matches, the next cycle shows `phy_ctrl` zero and `rsp_valid` with `rsp_timeout` = 1 and `rsp_rdata` = 0. No later step is run.
- R8: A successful response has `rsp_timeout` = 0, and a write response has `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_timeout | output | 1 | Transfer aborted on an acknowledge wait |
| rsp_rdata | output | 16 | Read data (0 for writes and timeouts) |
| phy_ctrl | output | 20 | Control word: [15:0] value, 16 address latch, 17 data latch, 18 write, 19 read |
| phy_stat | input | 17 | Status word: [15:0] read data, 16 acknowledge |

## Verification
An internal state of the wrong step shows up on `phy_ctrl` in the cycle it is entered, because the control word is decoded only from the current step and the latched request. A poll counter that is off by one moves the step change by at least one cycle, and a wrong limit moves the timeout by a whole slot of `POLL_GAP` cycles. Both are seen within one wait window. A read value latched at the wrong sample, or a stale flag, shows up in the single response cycle that follows.

// File: rtl/phy_regport_pkg.sv
package phy_regport_pkg;

    typedef enum logic [3:0] {
        STP_IDLE,
        STP_ADR_SET,
        STP_ADR_CAP,
        STP_ADR_REL,
        STP_DAT_SET,
        STP_DAT_CAP,
        STP_DAT_REL,
        STP_WR_STB,
        STP_WR_REL,
        STP_RD_STB,
        STP_RD_REL,
        STP_RESP
    } step_t;

    typedef enum logic [1:0] {
        WT_NONE,
        WT_HIGH,
        WT_LOW
    } wait_t;

endpackage

// File: rtl/phy_regport_timer.sv
module phy_regport_timer #(
    parameter int POLL_GAP  = 4,
    parameter int MAX_POLLS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic sample_now,
    output logic last_poll
);
    localparam int GAP_W  = $clog2(POLL_GAP + 1);
    localparam int POLL_W = $clog2(MAX_POLLS + 1);

    typedef struct packed {
        logic [GAP_W-1:0]  gap;
        logic [POLL_W-1:0] poll;
    } tmr_t;

    tmr_t t_d, t_q;

    assign sample_now = (t_q.gap == GAP_W'(POLL_GAP - 1));
    assign last_poll  = (t_q.poll == POLL_W'(MAX_POLLS - 1));

    always_comb begin
        t_d = t_q;
        if (restart) begin
            t_d.gap  = '0;
            t_d.poll = '0;
        end else if (sample_now) begin
            t_d.gap = '0;
            if (!last_poll) begin
                t_d.poll = t_q.poll + 1'b1;
            end
        end else begin
            t_d.gap = t_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end
endmodule

// File: rtl/phy_regport_decode.sv
module phy_regport_decode
    import phy_regport_pkg::*;
#(
    parameter int DW = 16
) (
    input  step_t          step,
    input  logic           is_write,
    input  logic [DW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW+3:0]  ctrl,
    output wait_t          wkind,
    output step_t          step_next
);
    localparam int CAP_ADR = DW;
    localparam int CAP_DAT = DW + 1;
    localparam int WR_BIT  = DW + 2;
    localparam int RD_BIT  = DW + 3;

    always_comb begin
        ctrl      = '0;
        wkind     = WT_NONE;
        step_next = step;
        unique case (step)
            STP_ADR_SET: begin
                ctrl[DW-1:0] = addr;
                step_next    = STP_ADR_CAP;
            end
            STP_ADR_CAP: begin
                ctrl[DW-1:0]  = addr;
                ctrl[CAP_ADR] = 1'b1;
                wkind         = WT_HIGH;
                step_next     = STP_ADR_REL;
            end
            STP_ADR_REL: begin
                ctrl[DW-1:0] = addr;
                wkind        = WT_LOW;
                step_next    = is_write ? STP_DAT_SET : STP_RD_STB;
            end
            STP_DAT_SET: begin
                ctrl[DW-1:0] = wdata;
                step_next    = STP_DAT_CAP;
            end
            STP_DAT_CAP: begin
                ctrl[DW-1:0]  = wdata;
                ctrl[CAP_DAT] = 1'b1;
                wkind         = WT_HIGH;
                step_next     = STP_DAT_REL;
            end
            STP_DAT_REL: begin
                ctrl[DW-1:0] = wdata;
                wkind        = WT_LOW;
                step_next    = STP_WR_STB;
            end
            STP_WR_STB: begin
                ctrl[WR_BIT] = 1'b1;
                wkind        = WT_HIGH;
                step_next    = STP_WR_REL;
            end
            STP_WR_REL: begin
                ctrl[DW-1:0] = wdata;
                wkind        = WT_LOW;
                step_next    = STP_RESP;
            end
            STP_RD_STB: begin
                ctrl[RD_BIT] = 1'b1;
                wkind        = WT_HIGH;
                step_next    = STP_RD_REL;
            end
            STP_RD_REL: begin
                wkind     = WT_LOW;
                step_next = STP_RESP;
            end
            STP_RESP:  step_next = STP_IDLE;
            default:   step_next = step;
        endcase
    end
endmodule

// File: rtl/phy_regport_master.sv
module phy_regport_master
    import phy_regport_pkg::*;
#(
    parameter int DW        = 16,
    parameter int POLL_GAP  = 4,
    parameter int MAX_POLLS = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_write,
    input  logic [DW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           rsp_valid,
    output logic           rsp_timeout,
    output logic [DW-1:0]  rsp_rdata,
    output logic [DW+3:0]  phy_ctrl,
    input  logic [DW:0]    phy_stat
);
    typedef struct packed {
        step_t          step;
        logic           is_wr;
        logic [DW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [DW-1:0]  rdata;
        logic           tmo;
    } mst_t;

    mst_t s_d, s_q;

    wait_t wkind;
    step_t step_nx;
    logic  sample_now, last_poll, restart, ack;

    assign ack = phy_stat[DW];

    phy_regport_decode #(.DW(DW)) u_dec (
        .step      (s_q.step),
        .is_write  (s_q.is_wr),
        .addr      (s_q.addr),
        .wdata     (s_q.wdata),
        .ctrl      (phy_ctrl),
        .wkind     (wkind),
        .step_next (step_nx)
    );

    phy_regport_timer #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .sample_now (sample_now),
        .last_poll  (last_poll)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.step)
            STP_IDLE: begin
                if (req_valid) begin
                    s_d.step  = STP_ADR_SET;
                    s_d.is_wr = req_write;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    s_d.rdata = '0;
                    s_d.tmo   = 1'b0;
                end
            end
            STP_RESP: s_d.step = STP_IDLE;
            default: begin
                if (wkind == WT_NONE) begin
                    s_d.step = step_nx;
                end else if (sample_now) begin
                    if (ack == (wkind == WT_HIGH)) begin
                        if (s_q.step == STP_RD_STB) begin
                            s_d.rdata = phy_stat[DW-1:0];
                        end
                        s_d.step = step_nx;
                    end else if (last_poll) begin
                        s_d.tmo   = 1'b1;
                        s_d.rdata = '0;
                        s_d.step  = STP_RESP;
                    end
                end
            end
        endcase
    end

    assign restart     = (s_d.step != s_q.step);
    assign req_ready   = (s_q.step == STP_IDLE);
    assign rsp_valid   = (s_q.step == STP_RESP);
    assign rsp_timeout = s_q.tmo;
    assign rsp_rdata   = s_q.rdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{step: STP_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/phy_regport_master_chk.sv
module phy_regport_master_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          rsp_timeout,
    input logic [DW-1:0] rsp_rdata,
    input logic [DW+3:0] phy_ctrl
);
    // R2
    rsp_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R2
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    rsp_ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (phy_ctrl == '0));

    // R7
    tmo_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_timeout) |-> (rsp_rdata == '0));

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_ctrl[DW+3:DW]));

    // R3
    adr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_ctrl[DW]) |-> $stable(phy_ctrl[DW-1:0]));

    // R4
    dat_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_ctrl[DW+1]) |-> $stable(phy_ctrl[DW-1:0]));

    // R4
    wr_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_ctrl[DW+2] |-> (phy_ctrl[DW-1:0] == '0));

    // R5
    rd_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_ctrl[DW+3] |-> (phy_ctrl[DW-1:0] == '0));
endmodule

bind phy_regport_master phy_regport_master_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_timeout (rsp_timeout),
    .rsp_rdata   (rsp_rdata),
    .phy_ctrl    (phy_ctrl)
);

// File: tb/phy_regport_master_tb.sv
module phy_regport_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 16;
    localparam int GAP  = 4;
    localparam int MAXP = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic rsp_valid, rsp_timeout;
    logic [15:0] rsp_rdata;
    logic [19:0] phy_ctrl;
    logic [16:0] phy_stat;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_regport_master #(.DW(DW), .POLL_GAP(GAP), .MAX_POLLS(MAXP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
        .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
    );

    // ---------------- behavioural PHY ----------------
    int phy_lat = 1;
    int phy_mode = 0;           // 0 normal, 1 never acks, 2 ack stuck high
    int phy_cnt = 0;
    logic phy_ack = 1'b0;
    logic [15:0] phy_adr = '0, phy_dat = '0, phy_rd = '0;
    logic [15:0] phy_mem [0:255];
    logic [15:0] shadow  [0:255];

    initial begin
        for (int i = 0; i < 256; i++) begin
            phy_mem[i] = '0;
            shadow[i]  = '0;
        end
    end

    assign phy_stat = {(phy_mode == 1) ? 1'b0 : (phy_mode == 2) ? 1'b1 : phy_ack, phy_rd};

    always @(posedge clk) begin
        logic lvl;
        lvl = |phy_ctrl[19:16];
        if (phy_mode == 0) begin
            if (lvl != phy_ack) begin
                if (phy_cnt + 1 >= phy_lat) begin
                    phy_ack <= lvl;
                    phy_cnt <= 0;
                    if (lvl) begin
                        if (phy_ctrl[16]) phy_adr <= phy_ctrl[15:0];
                        if (phy_ctrl[17]) phy_dat <= phy_ctrl[15:0];
                        if (phy_ctrl[18]) phy_mem[phy_adr[7:0]] <= phy_dat;
                        if (phy_ctrl[19]) phy_rd <= phy_mem[phy_adr[7:0]];
                    end
                end else begin
                    phy_cnt <= phy_cnt + 1;
                end
            end else begin
                phy_cnt <= 0;
            end
        end
    end

    // ---------------- reference model ----------------
    int m_mode = 0;             // 0 idle, 1 running, 2 response
    int m_n = 0, m_idx = 0, m_k = 0;
    logic [19:0] m_ctl [0:15];
    int m_kind [0:15];          // 0 none, 1 wait high, 2 wait low
    logic [19:0] e_ctrl = '0;
    logic e_ready = 1'b1, e_rsp = 1'b0, e_tmo = 1'b0;
    logic [15:0] e_rdata = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode <= 0; e_ctrl <= '0; e_ready <= 1'b1; e_rsp <= 1'b0;
            e_tmo <= 1'b0; e_rdata <= '0;
        end else begin
            case (m_mode)
                0: if (req_valid) begin
                    int n;
                    n = 0;
                    m_ctl[n] = {4'h0, req_addr};  m_kind[n] = 0; n++;
                    m_ctl[n] = {4'h1, req_addr};  m_kind[n] = 1; n++;
                    m_ctl[n] = {4'h0, req_addr};  m_kind[n] = 2; n++;
                    if (req_write) begin
                        m_ctl[n] = {4'h0, req_wdata}; m_kind[n] = 0; n++;
                        m_ctl[n] = {4'h2, req_wdata}; m_kind[n] = 1; n++;
                        m_ctl[n] = {4'h0, req_wdata}; m_kind[n] = 2; n++;
                        m_ctl[n] = {4'h4, 16'h0};     m_kind[n] = 1; n++;
                        m_ctl[n] = {4'h0, req_wdata}; m_kind[n] = 2; n++;
                    end else begin
                        m_ctl[n] = {4'h8, 16'h0};     m_kind[n] = 1; n++;
                        m_ctl[n] = 20'h0;             m_kind[n] = 2; n++;
                    end
                    m_n <= n; m_idx <= 0; m_k <= 0; m_mode <= 1;
                    e_ctrl <= m_ctl[0]; e_ready <= 1'b0;
                    e_tmo <= 1'b0; e_rdata <= '0;
                end
                1: begin
                    bit adv;
                    adv = 0;
                    if (m_kind[m_idx] == 0) adv = 1;
                    else if ((m_k % GAP) == GAP - 1) begin
                        if (phy_stat[16] == (m_kind[m_idx] == 1)) begin
                            if (m_ctl[m_idx][19]) e_rdata <= phy_stat[15:0];
                            adv = 1;
                        end else if ((m_k / GAP) == MAXP - 1) begin
                            m_mode <= 2; e_ctrl <= '0; e_rsp <= 1'b1;
                            e_tmo <= 1'b1; e_rdata <= '0;
                        end else m_k <= m_k + 1;
                    end else m_k <= m_k + 1;
                    if (adv) begin
                        m_k <= 0;
                        if (m_idx + 1 == m_n) begin
                            m_mode <= 2; e_ctrl <= '0; e_rsp <= 1'b1;
                        end else begin
                            m_idx <= m_idx + 1; e_ctrl <= m_ctl[m_idx + 1];
                        end
                    end
                end
                default: begin
                    m_mode <= 0; e_rsp <= 1'b0; e_ready <= 1'b1;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            chk("R3 R4 R5 R6 phy_ctrl", 32'(phy_ctrl), 32'(e_ctrl));
            chk("R2 req_ready", 32'(req_ready), 32'(e_ready));
            chk("R2 rsp_valid", 32'(rsp_valid), 32'(e_rsp));
            if (e_rsp) begin
                chk("R7 rsp_timeout", 32'(rsp_timeout), 32'(e_tmo));
                chk("R5 rsp_rdata", 32'(rsp_rdata), 32'(e_rdata));
            end
            if (cycles > 150000) begin
                n_bad++;
                $display("FAIL watchdog expired");
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    task automatic xfer(input logic wr, input logic [15:0] a, input logic [15:0] d,
                        input logic exp_to);
        logic [15:0] exp_rd;
        while (!req_ready) @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R2: a second request while busy must be ignored
        req_write = 1'b1; req_addr = 16'h00FF; req_wdata = 16'hDEAD; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 busy after accept", 32'(req_ready), 32'h0);
        while (!rsp_valid) @(negedge clk);
        exp_rd = (wr || exp_to) ? 16'h0 : shadow[a[7:0]];
        chk("R7 R8 timeout flag", 32'(rsp_timeout), 32'(exp_to));
        chk("R5 R8 read data", 32'(rsp_rdata), 32'(exp_rd));
        if (wr && !exp_to) shadow[a[7:0]] = d;
        @(negedge clk);
        chk("R2 ready after response", 32'(req_ready), 32'h1);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready at reset", 32'(req_ready), 32'h1);
        chk("R1 ctrl at reset", 32'(phy_ctrl), 32'h0);
        chk("R1 rsp at reset", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        phy_lat = 1;  xfer(1'b1, 16'h0005, 16'h1234, 1'b0);
        phy_lat = 3;  xfer(1'b0, 16'h0005, 16'h0, 1'b0);
        phy_lat = 2;  xfer(1'b1, 16'h0011, 16'hBEEF, 1'b0);
        phy_lat = 5;  xfer(1'b0, 16'h0011, 16'h0, 1'b0);
        phy_lat = 30; xfer(1'b1, 16'h0042, 16'hA5A5, 1'b0);
        phy_lat = 7;  xfer(1'b0, 16'h0042, 16'h0, 1'b0);
        phy_lat = 60; xfer(1'b1, 16'h0007, 16'h7777, 1'b1);   // R7 slow PHY
        repeat (80) @(negedge clk);
        phy_lat = 1;  xfer(1'b0, 16'h0007, 16'h0, 1'b0);      // R7 no write landed
        phy_mode = 1; xfer(1'b0, 16'h0005, 16'h0, 1'b1);      // R7 dead PHY
        phy_mode = 2; xfer(1'b1, 16'h0005, 16'h9999, 1'b1);   // R7 ack stuck high
        phy_mode = 0;
        repeat (20) @(negedge clk);
        phy_lat = 1;  xfer(1'b0, 16'h0005, 16'h0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            phy_lat = 1 + i * 4;
            xfer(1'b1, 16'(8'h20 + i), 16'(16'h0F00 + i * 3), 1'b0);
            xfer(1'b0, 16'(8'h20 + i), 16'h0, 1'b0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule